// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor that completes one instruction on every clock edge. It covers a small integer subset: the register-register forms add, addu and slt; the immediate forms addi, andi, ori, slti and lui; word load and store; and the two equality branches. The core holds a program counter, a 32-entry register file, immediate extension, an ALU, a main decoder and an ALU-function decoder. There are no traps, no pipeline and no caches.

The instruction store and the data store are internal word arrays. Each has its own write port at the block edge. A test harness fills both stores while reset is held, then releases reset so that execution starts at address 0. A combinational debug port returns the value of any register, and the current program counter is driven out on every cycle.

Top module: `onecycle_cpu`

## Requirements
- R1: Every instruction retires in one clock. When no branch is taken, the PC advances by 4. A 3-instruction preamble followed by a 7-instruction loop that runs five times ends after exactly 38 cycles.
- R2: Reset is synchronous and active high. It sets the PC to 0 and clears all 32 registers.
- R3: beq (opcode 000100) branches when rs equals rt. bne (opcode 000101) branches when they differ. The target is PC+4 plus the sign-extended 16-bit field shifted left by two.
- R4: lui (opcode 001111) puts its 16-bit field into bits 31:16 of rt and writes zeros to bits 15:0.
- R5: Register 0 always reads as zero, and a write to it leaves it zero.
- R6: slt (funct 101010) and slti (opcode 001010) compare as signed numbers. They write 1 when the first operand is smaller and 0 otherwise.
- R7: lw (opcode 100011) and sw (opcode 101011) form the byte address as rs plus the sign-extended offset. The data word index is address bits [DMEM_AW+1:2]. A store writes no register.
- R8: andi (001100) and ori (001101) zero-extend their immediate. addi (001000), slti, lw, sw and the branches sign-extend theirs.
- R9: R-format (opcode 000000) add (funct 100000) and addu (funct 100001) write rs+rt to rd. add, addu and addi wrap modulo 2^32 and never trap.
- R10: An instruction word written through the instruction load port at index i is fetched at byte address 4*i. A data word written through the data load port is returned by a later lw of that index.
- R11: A program that sums the data words 5, -5, 10, -10 and -123 leaves -123 (0xFFFFFF85) in register 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_ld_we | input | 1 | Instruction store write enable |
| imem_ld_addr | input | IMEM_AW | Instruction store word index |
| imem_ld_data | input | 32 | Instruction word to write |
| dmem_ld_we | input | 1 | Data store write enable from the harness |
| dmem_ld_addr | input | DMEM_AW | Data store word index |
| dmem_ld_data | input | 32 | Data word to write |
| dbg_sel | input | 5 | Register number to observe |
| dbg_value | output | 32 | Value of the selected register |
| pc_value | output | 32 | Current program counter |

## Verification
The bench builds the core with a 64-word instruction store (IMEM_AW=6) and a 16-word data store (DMEM_AW=4). With the smaller data store, an address built by lui in the upper half-word falls onto low data indices, so the summing loop can form its pointer the long way and still reach loaded data. A store followed by a load at a negative offset also lands on a known slot. Both programs place a self-branch at the end. This keeps the PC parked after the last instruction, so the final register sweep sees stable state.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);

  localparam logic [5:0] OPC_RTYPE = 6'b000000;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_BNE   = 6'b000101;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_SLTI  = 6'b001010;
  localparam logic [5:0] OPC_ANDI  = 6'b001100;
  localparam logic [5:0] OPC_ORI   = 6'b001101;
  localparam logic [5:0] OPC_LUI   = 6'b001111;
  localparam logic [5:0] OPC_LW    = 6'b100011;
  localparam logic [5:0] OPC_SW    = 6'b101011;

  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SLT  = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_HI
  } alu_fn_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       rf_write;
    logic       st_write;
    logic       is_branch;
    logic       br_if_ne;
    logic       imm_zext;
    logic [1:0] alu_class;
  } ctrl_t;
endpackage

// File: rtl/oc_decode.sv
`timescale 1ns/1ps
module oc_decode
  import oc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl,
  output alu_fn_e    alu_fn
);
  always_comb begin
    ctl = '0;
    unique case (opcode)
      OPC_RTYPE: begin
        ctl.dst_is_rd = 1'b1;
        ctl.rf_write  = 1'b1;
        ctl.alu_class = 2'b10;
      end
      OPC_LW: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.rf_write    = 1'b1;
      end
      OPC_SW: begin
        ctl.b_is_imm = 1'b1;
        ctl.st_write = 1'b1;
      end
      OPC_BEQ, OPC_BNE: begin
        ctl.is_branch = 1'b1;
        ctl.br_if_ne  = (opcode == OPC_BNE);
        ctl.alu_class = 2'b01;
      end
      OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_LUI: begin
        ctl.b_is_imm  = 1'b1;
        ctl.rf_write  = 1'b1;
        ctl.imm_zext  = (opcode == OPC_ANDI) || (opcode == OPC_ORI);
        ctl.alu_class = 2'b11;
      end
      default: ctl = '0;
    endcase
  end

  always_comb begin
    alu_fn = ALU_ADD;
    unique case (ctl.alu_class)
      2'b01: alu_fn = ALU_SUB;
      2'b10: begin
        if (funct == FN_SLT) alu_fn = ALU_SLT;
        else                 alu_fn = ALU_ADD;
      end
      2'b11: begin
        unique case (opcode)
          OPC_ANDI: alu_fn = ALU_AND;
          OPC_ORI:  alu_fn = ALU_OR;
          OPC_SLTI: alu_fn = ALU_SLT;
          OPC_LUI:  alu_fn = ALU_HI;
          default:  alu_fn = ALU_ADD;
        endcase
      end
      default: alu_fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/oc_alu.sv
`timescale 1ns/1ps
module oc_alu
  import oc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         is_zero
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_HI:  y = {b[HALF-1:0], {HALF{1'b0}}};
      default: y = a + b;
    endcase
  end

  assign is_zero = (y == '0);
endmodule

// File: rtl/oc_regfile.sv
`timescale 1ns/1ps
module oc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_dbg
);
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_a   = (ra_a   == '0) ? '0 : regs[ra_a];
  assign rd_b   = (ra_b   == '0) ? '0 : regs[ra_b];
  assign rd_dbg = (ra_dbg == '0) ? '0 : regs[ra_dbg];
endmodule

// File: rtl/oc_ram.sv
`timescale 1ns/1ps
module oc_ram #(
  parameter int W  = 32,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/onecycle_cpu.sv
`timescale 1ns/1ps
module onecycle_cpu
  import oc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_ld_we,
  input  logic [IMEM_AW-1:0] imem_ld_addr,
  input  logic [XLEN-1:0]    imem_ld_data,
  input  logic               dmem_ld_we,
  input  logic [DMEM_AW-1:0] dmem_ld_addr,
  input  logic [XLEN-1:0]    dmem_ld_data,
  input  logic [RIDX-1:0]    dbg_sel,
  output logic [XLEN-1:0]    dbg_value,
  output logic [XLEN-1:0]    pc_value
);
  localparam int IMM_W = 16;

  logic [XLEN-1:0] pc_q, pc_inc, br_target;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, ld_word, wb_data;
  logic [IMM_W-1:0] imm16;
  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic            alu_zero, take_br, rf_we, core_mem_we;
  logic            dm_we;
  logic [DMEM_AW-1:0] dm_waddr, dm_raddr;
  logic [XLEN-1:0]    dm_wdata;
  ctrl_t           ctl;
  alu_fn_e         alu_fn;

  oc_ram #(.W(XLEN), .AW(IMEM_AW)) u_imem (
    .clk(clk), .we(imem_ld_we), .waddr(imem_ld_addr), .wdata(imem_ld_data),
    .raddr(pc_q[IMEM_AW+1:2]), .rdata(instr)
  );

  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign imm16  = instr[15:0];

  oc_decode u_dec (
    .opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl), .alu_fn(alu_fn)
  );

  assign wr_idx = ctl.dst_is_rd ? rd_idx : rt_idx;
  assign rf_we  = ctl.rf_write & ~rst;

  oc_regfile #(.W(XLEN), .DEPTH(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(wr_idx), .wdata(wb_data),
    .ra_a(rs_idx), .ra_b(rt_idx), .ra_dbg(dbg_sel),
    .rd_a(rs_val), .rd_b(rt_val), .rd_dbg(dbg_value)
  );

  assign imm_ext = ctl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, imm16}
                                : {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
  assign alu_b   = ctl.b_is_imm ? imm_ext : rt_val;

  oc_alu #(.W(XLEN)) u_alu (
    .a(rs_val), .b(alu_b), .fn(alu_fn), .y(alu_y), .is_zero(alu_zero)
  );

  // data store: harness writes take the port over the core's store
  assign core_mem_we = ctl.st_write & ~rst;
  assign dm_we    = dmem_ld_we | core_mem_we;
  assign dm_waddr = dmem_ld_we ? dmem_ld_addr : alu_y[DMEM_AW+1:2];
  assign dm_wdata = dmem_ld_we ? dmem_ld_data : rt_val;
  assign dm_raddr = alu_y[DMEM_AW+1:2];

  oc_ram #(.W(XLEN), .AW(DMEM_AW)) u_dmem (
    .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr(dm_raddr), .rdata(ld_word)
  );

  assign wb_data = ctl.wb_from_mem ? ld_word : alu_y;

  assign pc_inc    = pc_q + XLEN'(4);
  assign br_target = pc_inc + {imm_ext[XLEN-3:0], 2'b00};
  assign take_br   = ctl.is_branch & (ctl.br_if_ne ? ~alu_zero : alu_zero);

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (take_br) pc_q <= br_target;
    else              pc_q <= pc_inc;
  end

  assign pc_value = pc_q;
endmodule

// File: rtl/oc_checker.sv
`timescale 1ns/1ps
module oc_checker
  import oc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] instr,
  input logic            take_br,
  input logic [XLEN-1:0] wb_data,
  input logic            rf_we,
  input logic            core_mem_we,
  input logic [RIDX-1:0] dbg_sel,
  input logic [XLEN-1:0] dbg_value
);
  assert_pc_cleared_R2: assert property (@(posedge clk) rst |=> pc_q == '0);

  assert_pc_step_R1: assert property (@(posedge clk) disable iff (rst)
    !take_br |=> pc_q == $past(pc_q) + 32'd4);

  assert_branch_target_R3: assert property (@(posedge clk) disable iff (rst)
    take_br |=> pc_q == $past(pc_q) + 32'd4
                 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (rst)
    (dbg_sel == '0) |-> (dbg_value == '0));

  assert_upper_imm_R4: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OPC_LUI) |-> (wb_data == {instr[15:0], 16'h0000}));

  assert_compare_bit_R6: assert property (@(posedge clk) disable iff (rst)
    ((instr[31:26] == OPC_SLTI) ||
     ((instr[31:26] == OPC_RTYPE) && (instr[5:0] == FN_SLT)))
    |-> (wb_data[XLEN-1:1] == '0));

  assert_store_no_wb_R7: assert property (@(posedge clk) disable iff (rst)
    core_mem_we |-> !rf_we);
endmodule

bind onecycle_cpu oc_checker u_oc_checker (
  .clk(clk), .rst(rst), .pc_q(pc_q), .instr(instr), .take_br(take_br),
  .wb_data(wb_data), .rf_we(rf_we), .core_mem_we(core_mem_we),
  .dbg_sel(dbg_sel), .dbg_value(dbg_value)
);

// File: tb/test_onecycle_cpu.sv
`timescale 1ns/1ps
module test_onecycle_cpu;
  localparam int IAW = 6;
  localparam int DAW = 4;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic           imem_ld_we = 1'b0;
  logic [IAW-1:0] imem_ld_addr = '0;
  logic [31:0]    imem_ld_data = '0;
  logic           dmem_ld_we = 1'b0;
  logic [DAW-1:0] dmem_ld_addr = '0;
  logic [31:0]    dmem_ld_data = '0;
  logic [4:0]     dbg_sel = '0;
  logic [31:0]    dbg_value, pc_value;

  int total = 0;
  int bad = 0;

  always #(TCK/2) clk = ~clk;

  onecycle_cpu #(.IMEM_AW(IAW), .DMEM_AW(DAW)) i_onecycle_cpu (
    .clk(clk), .rst(rst),
    .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .dbg_sel(dbg_sel), .dbg_value(dbg_value), .pc_value(pc_value)
  );

  // behavioural reference state
  logic [31:0] m_reg [32];
  logic [31:0] m_imem [1 << IAW];
  logic [31:0] m_dmem [1 << DAW];
  logic [31:0] m_pc;
  logic [31:0] prog_q [$];
  logic [31:0] data_q [$];

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] w, a, b, sx, zx, nxt, ea;
    logic [5:0]  op;
    w  = m_imem[m_pc[IAW+1:2]];
    op = w[31:26];
    a  = m_reg[w[25:21]];
    b  = m_reg[w[20:16]];
    sx = {{16{w[15]}}, w[15:0]};
    zx = {16'd0, w[15:0]};
    ea = a + sx;
    nxt = m_pc + 4;
    case (op)
      6'h00: begin
        if (w[5:0] == 6'h2A) m_reg[w[15:11]] = ($signed(a) < $signed(b)) ? 1 : 0;
        else                 m_reg[w[15:11]] = a + b;
      end
      6'h08: m_reg[w[20:16]] = a + sx;
      6'h0A: m_reg[w[20:16]] = ($signed(a) < $signed(sx)) ? 1 : 0;
      6'h0C: m_reg[w[20:16]] = a & zx;
      6'h0D: m_reg[w[20:16]] = a | zx;
      6'h0F: m_reg[w[20:16]] = {w[15:0], 16'd0};
      6'h23: m_reg[w[20:16]] = m_dmem[ea[DAW+1:2]];
      6'h2B: m_dmem[ea[DAW+1:2]] = b;
      6'h04: if (a == b) nxt = m_pc + 4 + (sx << 2);
      6'h05: if (a != b) nxt = m_pc + 4 + (sx << 2);
      default: ;
    endcase
    m_reg[0] = '0;
    m_pc = nxt;
  endtask

  // hold reset, load both stores, release reset
  task automatic load_and_start();
    rst = 1'b1;
    @(negedge clk);
    foreach (prog_q[i]) begin
      imem_ld_we = 1'b1; imem_ld_addr = IAW'(i); imem_ld_data = prog_q[i];
      m_imem[i] = prog_q[i];
      @(negedge clk);
    end
    imem_ld_we = 1'b0;
    foreach (data_q[i]) begin
      dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(i); dmem_ld_data = data_q[i];
      m_dmem[i] = data_q[i];
      @(negedge clk);
    end
    dmem_ld_we = 1'b0;
    check("R2 pc under reset", pc_value, 32'd0);
    for (int r = 0; r < 32; r++) begin
      dbg_sel = 5'(r);
      #0.2;
      if (r == 4 || r == 8 || r == 31) check("R2 reg cleared", dbg_value, 32'd0);
    end
    for (int r = 0; r < 32; r++) m_reg[r] = '0;
    m_pc = '0;
    rst = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      check("R1 pc vs model", pc_value, m_pc);
      dbg_sel = 5'(c % 32);
      #1;
      check("R9 reg vs model", dbg_value, m_reg[c % 32]);
    end
  endtask

  task automatic peek(input string what, input int r, input logic [31:0] exp);
    dbg_sel = 5'(r);
    #0.2;
    check(what, dbg_value, exp);
  endtask

  initial begin
    #(TCK * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // program A: sum five words through a lui-based pointer
    prog_q = {};
    prog_q.push_back(enc_i(6'h0D, 5'd0, 5'd8, 16'd0));
    prog_q.push_back(enc_i(6'h0D, 5'd0, 5'd4, 16'd0));
    prog_q.push_back(enc_i(6'h0D, 5'd0, 5'd9, 16'd20));
    prog_q.push_back(enc_i(6'h0F, 5'd0, 5'd1, 16'h2000));   // 12: loop top
    prog_q.push_back(enc_r(5'd1, 5'd8, 5'd1, 6'h21));
    prog_q.push_back(enc_i(6'h23, 5'd1, 5'd5, 16'd0));
    prog_q.push_back(enc_r(5'd4, 5'd5, 5'd4, 6'h20));
    prog_q.push_back(enc_i(6'h08, 5'd8, 5'd8, 16'd4));
    prog_q.push_back(enc_r(5'd8, 5'd9, 5'd1, 6'h2A));
    prog_q.push_back(enc_i(6'h05, 5'd1, 5'd0, 16'hFFF9));   // 36: back to 12
    prog_q.push_back(enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));   // 40: park
    data_q = {32'd5, -32'sd5, 32'd10, -32'sd10, -32'sd123};
    load_and_start();
    run_cycles(3);
    check("R1 pc after preamble", pc_value, 32'd12);
    run_cycles(35);
    check("R1 pc after 38 cycles", pc_value, 32'd40);
    peek("R10 R11 sum in reg 4", 4, 32'hFFFFFF85);
    peek("R3 loop index reg 8", 8, 32'd20);
    peek("R6 slt false after loop", 1, 32'd0);
    run_cycles(4);
    check("R3 park loop holds pc", pc_value, 32'd40);

    // program B: immediates, compares, memory, branches
    prog_q = {};
    prog_q.push_back(enc_i(6'h08, 5'd0, 5'd2, 16'hFFFB));   // 0
    prog_q.push_back(enc_i(6'h0D, 5'd0, 5'd3, 16'h8001));   // 4
    prog_q.push_back(enc_i(6'h0C, 5'd2, 5'd4, 16'hFFF0));   // 8
    prog_q.push_back(enc_i(6'h0F, 5'd0, 5'd5, 16'hABCD));   // 12
    prog_q.push_back(enc_i(6'h0A, 5'd2, 5'd6, 16'hFFFF));   // 16
    prog_q.push_back(enc_r(5'd3, 5'd2, 5'd7, 6'h2A));       // 20
    prog_q.push_back(enc_i(6'h08, 5'd0, 5'd0, 16'd7));      // 24
    prog_q.push_back(enc_i(6'h2B, 5'd0, 5'd5, 16'd8));      // 28
    prog_q.push_back(enc_i(6'h08, 5'd0, 5'd9, 16'd16));     // 32
    prog_q.push_back(enc_i(6'h23, 5'd9, 5'd10, 16'hFFF8));  // 36
    prog_q.push_back(enc_i(6'h04, 5'd6, 5'd7, 16'd1));      // 40 not taken
    prog_q.push_back(enc_r(5'd2, 5'd3, 5'd11, 6'h21));      // 44
    prog_q.push_back(enc_i(6'h0F, 5'd0, 5'd13, 16'h7FFF));  // 48
    prog_q.push_back(enc_i(6'h0D, 5'd13, 5'd13, 16'hFFFF)); // 52
    prog_q.push_back(enc_i(6'h08, 5'd13, 5'd14, 16'd1));    // 56
    prog_q.push_back(enc_i(6'h05, 5'd6, 5'd0, 16'd1));      // 60 taken
    prog_q.push_back(enc_i(6'h08, 5'd0, 5'd12, 16'd99));    // 64 skipped
    prog_q.push_back(enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));   // 68 park
    data_q = {};
    load_and_start();
    run_cycles(20);
    check("R3 pc parked after taken bne", pc_value, 32'd68);
    peek("R8 addi sign-extends", 2, 32'hFFFFFFFB);
    peek("R8 ori zero-extends", 3, 32'h00008001);
    peek("R8 andi zero-extends", 4, 32'h0000FFF0);
    peek("R4 lui upper half", 5, 32'hABCD0000);
    peek("R6 slti signed true", 6, 32'd1);
    peek("R6 slt signed false", 7, 32'd0);
    peek("R5 reg 0 ignores write", 0, 32'd0);
    peek("R7 lw negative offset after sw", 10, 32'hABCD0000);
    peek("R9 addu result", 11, 32'h00007FFC);
    peek("R9 addi wraps without trap", 14, 32'h80000000);
    peek("R3 instruction after taken bne skipped", 12, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule